// File: doc/BRIEF.md
# Extended PHY Register Indirect Access Sequencer

This block reaches extended (per-device) PHY registers when only plain five-bit management register accesses are available. It takes one request at a time. A request carries a 32-bit target, a write flag and 16 bits of write data. The upper half of the target selects the device and the lower half selects the register inside that device.

For a nonzero device, the block runs a fixed chain of five register accesses on a downstream access port. It first loads the device into the access-control register (13) and the register address into the address/data register (14). It then switches register 13 into data mode without post-increment and moves the data through register 14. Finally it writes register 13 back to zero. A device value of zero skips the chain and makes one direct access instead.

Each downstream access is a valid/ready request followed by a completion. The completion carries read data and an error flag. The requester sees a one-cycle done strobe, and the read data and error status come with it in the same cycle.

Top module: `mmd_indirect_seq`

## Requirements
- R1: After reset, reqReady is 1, and dsValid and doneValid are 0.
- R2: When target bits 31:16 are zero, the block makes exactly one downstream access. That access uses register number target[4:0] and the request's write flag. Its data is the write data for a write and zero for a read. A direct read returns the completion data on doneRdata.
- R3: When target bits 31:16 are nonzero, the first access writes register 13 with the device value (target[31:16]). The second access writes register 14 with target[15:0].
- R4: The third access writes register 13 with the device value ORed with 0x4000 (data mode, no post-increment).
- R5: The fourth access targets register 14. For a read it is a read with data zero, and its completion data appears on doneRdata. For a write it carries the write data.
- R6: The fifth and last access writes register 13 with zero.
- R7: A completion with its error flag set ends the request at once. No further access is issued, doneErr is 1 and doneRdata is 0.
- R8: dsValid stays high with register number, write flag and data unchanged until dsReady is high. The next access is issued only after the previous one has completed.
- R9: reqReady is high only while the block is idle. A request presented while the block is busy is ignored and issues no access.
- R10: doneValid is high for exactly one cycle, in the cycle after the final completion is taken. reqReady returns in the following cycle. Write requests end with doneRdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and accepting a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTarget | input | 32 | Device value [31:16], register address [15:0] |
| reqWdata | input | 16 | Write data |
| doneValid | output | 1 | One-cycle completion strobe |
| doneRdata | output | 16 | Read result (zero on write or error) |
| doneErr | output | 1 | Request aborted on a downstream error |
| dsValid | output | 1 | Downstream access request valid |
| dsReady | input | 1 | Downstream accepts the request |
| dsRegNum | output | 5 | Downstream register number |
| dsWrite | output | 1 | Downstream write flag |
| dsWdata | output | 16 | Downstream write data |
| cplValid | input | 1 | Downstream completion valid |
| cplRdata | input | 16 | Downstream completion read data |
| cplErr | input | 1 | Downstream completion error |

## Verification
A wrong step counter or step decode shows up on the first affected downstream handshake as a wrong register number or data word. It appears at the very access where the order departs. A control state that skips or repeats a step changes the number of accesses logged before done, and it moves the done strobe away from the cycle after the last completion. So every request is judged on its full access list and on the exact done cycle. A busy flag that clears early shows up at reqReady in the same cycle. With a request held asserted across a busy period, it also shows up as extra accesses right after done.

// File: rtl/mmd_seq_pkg.sv
package mmd_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  // Order of the indirect steps matters: the controller advances by +1.
  typedef enum logic [2:0] {
    STEP_DEVSEL = 3'd0,
    STEP_ADDR   = 3'd1,
    STEP_MODE   = 3'd2,
    STEP_DATA   = 3'd3,
    STEP_CLEAR  = 3'd4,
    STEP_DIRECT = 3'd5
  } seq_step_e;

  typedef struct packed {
    logic      load;
    logic      capRd;
    logic      setErr;
    seq_step_e step;
  } seq_ctl_s;

endpackage

// File: rtl/mmd_seq_ctrl.sv
module mmd_seq_ctrl
  import mmd_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     newDirect,
  input  logic     isRead,
  input  logic     dsReady,
  input  logic     cplValid,
  input  logic     cplErr,
  output logic     reqReady,
  output logic     dsValid,
  output logic     doneValid,
  output seq_ctl_s ctl
);

  seq_state_e state;
  seq_step_e  step;
  logic       lastStep;

  assign lastStep  = (step == STEP_CLEAR) || (step == STEP_DIRECT);
  assign reqReady  = (state == ST_IDLE);
  assign dsValid   = (state == ST_ISSUE);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    ctl        = '0;
    ctl.step   = step;
    ctl.load   = (state == ST_IDLE) && reqValid;
    if (state == ST_WAIT && cplValid) begin
      if (cplErr) begin
        ctl.setErr = 1'b1;
      end else if (isRead && (step == STEP_DATA || step == STEP_DIRECT)) begin
        ctl.capRd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= STEP_DEVSEL;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_ISSUE;
          step  <= newDirect ? STEP_DIRECT : STEP_DEVSEL;
        end
        ST_ISSUE: if (dsReady) state <= ST_WAIT;
        ST_WAIT: if (cplValid) begin
          if (cplErr || lastStep) begin
            state <= ST_DONE;
          end else begin
            state <= ST_ISSUE;
            step  <= seq_step_e'(step + 3'd1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  ds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsValid && !dsReady |=> dsValid);

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsValid && dsReady |=> !dsValid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid && reqReady);

endmodule

// File: rtl/mmd_seq_dp.sv
module mmd_seq_dp
  import mmd_seq_pkg::*;
#(
  parameter int DEV_W     = 16,
  parameter int REG_W     = 16,
  parameter int DATA_W    = 16,
  parameter int RNUM_W    = 5,
  parameter int CTRL_REG  = 13,
  parameter int AD_REG    = 14,
  parameter int MODE_BIT  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  seq_ctl_s                ctl,
  input  logic                    reqWrite,
  input  logic [DEV_W+REG_W-1:0]  reqTarget,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [DATA_W-1:0]       cplRdata,
  output logic                    newDirect,
  output logic                    isRead,
  output logic [RNUM_W-1:0]       dsRegNum,
  output logic                    dsWrite,
  output logic [DATA_W-1:0]       dsWdata,
  output logic [DATA_W-1:0]       doneRdata,
  output logic                    doneErr
);

  localparam logic [RNUM_W-1:0] CTRL_NUM  = RNUM_W'(CTRL_REG);
  localparam logic [RNUM_W-1:0] AD_NUM    = RNUM_W'(AD_REG);
  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(1) << MODE_BIT;

  logic [DEV_W-1:0]  devReg;
  logic [REG_W-1:0]  regAddr;
  logic              wrReg;
  logic [DATA_W-1:0] wdReg;
  logic [DATA_W-1:0] rdReg;
  logic              errReg;

  assign newDirect = (reqTarget[DEV_W+REG_W-1:REG_W] == '0);
  assign isRead    = !wrReg;
  assign doneErr   = errReg;
  assign doneRdata = errReg ? '0 : rdReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devReg  <= '0;
      regAddr <= '0;
      wrReg   <= 1'b0;
      wdReg   <= '0;
      rdReg   <= '0;
      errReg  <= 1'b0;
    end else if (ctl.load) begin
      devReg  <= reqTarget[DEV_W+REG_W-1:REG_W];
      regAddr <= reqTarget[REG_W-1:0];
      wrReg   <= reqWrite;
      wdReg   <= reqWdata;
      rdReg   <= '0;
      errReg  <= 1'b0;
    end else begin
      if (ctl.capRd)  rdReg  <= cplRdata;
      if (ctl.setErr) errReg <= 1'b1;
    end
  end

  always_comb begin
    dsRegNum = CTRL_NUM;
    dsWrite  = 1'b1;
    dsWdata  = '0;
    unique case (ctl.step)
      STEP_DEVSEL: dsWdata = DATA_W'(devReg);
      STEP_ADDR: begin
        dsRegNum = AD_NUM;
        dsWdata  = DATA_W'(regAddr);
      end
      STEP_MODE:   dsWdata = DATA_W'(devReg) | MODE_MASK;
      STEP_DATA: begin
        dsRegNum = AD_NUM;
        dsWrite  = wrReg;
        dsWdata  = wrReg ? wdReg : '0;
      end
      STEP_CLEAR:  dsWdata = '0;
      STEP_DIRECT: begin
        dsRegNum = regAddr[RNUM_W-1:0];
        dsWrite  = wrReg;
        dsWdata  = wrReg ? wdReg : '0;
      end
      default: ;
    endcase
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errReg && !ctl.load |=> errReg);

endmodule

// File: rtl/mmd_indirect_seq.sv
module mmd_indirect_seq
  import mmd_seq_pkg::*;
#(
  parameter int DEV_W    = 16,
  parameter int REG_W    = 16,
  parameter int DATA_W   = 16,
  parameter int RNUM_W   = 5,
  parameter int CTRL_REG = 13,
  parameter int AD_REG   = 14,
  parameter int MODE_BIT = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [DEV_W+REG_W-1:0] reqTarget,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   doneValid,
  output logic [DATA_W-1:0]      doneRdata,
  output logic                   doneErr,
  output logic                   dsValid,
  input  logic                   dsReady,
  output logic [RNUM_W-1:0]      dsRegNum,
  output logic                   dsWrite,
  output logic [DATA_W-1:0]      dsWdata,
  input  logic                   cplValid,
  input  logic [DATA_W-1:0]      cplRdata,
  input  logic                   cplErr
);

  seq_ctl_s ctl;
  logic     newDirect;
  logic     isRead;

  mmd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .newDirect (newDirect),
    .isRead    (isRead),
    .dsReady   (dsReady),
    .cplValid  (cplValid),
    .cplErr    (cplErr),
    .reqReady  (reqReady),
    .dsValid   (dsValid),
    .doneValid (doneValid),
    .ctl       (ctl)
  );

  mmd_seq_dp #(
    .DEV_W    (DEV_W),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W),
    .RNUM_W   (RNUM_W),
    .CTRL_REG (CTRL_REG),
    .AD_REG   (AD_REG),
    .MODE_BIT (MODE_BIT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .reqWrite  (reqWrite),
    .reqTarget (reqTarget),
    .reqWdata  (reqWdata),
    .cplRdata  (cplRdata),
    .newDirect (newDirect),
    .isRead    (isRead),
    .dsRegNum  (dsRegNum),
    .dsWrite   (dsWrite),
    .dsWdata   (dsWdata),
    .doneRdata (doneRdata),
    .doneErr   (doneErr)
  );

  // R8
  ds_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsValid && !dsReady |=> $stable(dsRegNum) && $stable(dsWrite) && $stable(dsWdata));

  // R7
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && doneErr |-> doneRdata == '0);

endmodule

// File: tb/mmd_indirect_seq_test.sv
module mmd_indirect_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqTarget = '0;
  logic [15:0] reqWdata = '0;
  logic        doneValid;
  logic [15:0] doneRdata;
  logic        doneErr;
  logic        dsValid;
  logic        dsReady = 1'b0;
  logic [4:0]  dsRegNum;
  logic        dsWrite;
  logic [15:0] dsWdata;
  logic        cplValid = 1'b0;
  logic [15:0] cplRdata = '0;
  logic        cplErr = 1'b0;

  always #2 clk = ~clk;

  mmd_indirect_seq uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqTarget(reqTarget), .reqWdata(reqWdata),
    .doneValid(doneValid), .doneRdata(doneRdata), .doneErr(doneErr),
    .dsValid(dsValid), .dsReady(dsReady), .dsRegNum(dsRegNum),
    .dsWrite(dsWrite), .dsWdata(dsWdata), .cplValid(cplValid),
    .cplRdata(cplRdata), .cplErr(cplErr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural downstream model and observation
  int gotReg[$];
  int gotWr[$];
  int gotData[$];
  int cycle = 0;
  int lastCplCycle = -10;
  int doneCycle = -10;
  int doneSeen = 0;
  int doneErrS = 0;
  int doneRdS = 0;
  bit acceptSeen = 0;
  bit busy = 0;
  bit hsFlag = 0;
  bit pend = 0;
  int cnt = 0;
  int txnIdx = 0;
  int errAt = -1;
  int latency = 0;
  bit stallOn = 0;
  logic [15:0] rdVal = '0;
  bit heldPrev = 0;
  int heldReg, heldWr, heldData;
  bit resetDone = 0;

  always @(posedge clk) begin
    cycle++;
    if (resetDone) begin
      if (heldPrev) begin
        // R8 request held with the same fields while not accepted
        chk(dsValid == 1'b1, "R8 hold valid", dsValid, 1);
        chk(dsRegNum == heldReg && dsWrite == heldWr && dsWdata == heldData,
            "R8 stable fields", dsRegNum, heldReg);
      end
      heldPrev = dsValid && !dsReady;
      heldReg = dsRegNum; heldWr = dsWrite; heldData = dsWdata;
      if (dsValid && dsReady) begin
        gotReg.push_back(dsRegNum);
        gotWr.push_back(dsWrite);
        gotData.push_back(dsWdata);
        hsFlag = 1;
      end
      if (cplValid) lastCplCycle = cycle;
      if (reqValid && reqReady) begin acceptSeen = 1; busy = 1; end
      if (doneValid) begin
        doneSeen++; doneCycle = cycle; doneErrS = doneErr; doneRdS = doneRdata; busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (resetDone) begin
      // R9 ready only while idle, per-cycle model
      chk(reqReady == !busy, "R9 reqReady model", reqReady, !busy);
      if (hsFlag) begin hsFlag = 0; pend = 1; cnt = latency; end
      cplValid = 1'b0;
      cplErr = 1'b0;
      cplRdata = 16'h0;
      if (pend) begin
        if (cnt == 0) begin
          cplValid = 1'b1;
          cplErr = (txnIdx == errAt);
          cplRdata = (gotWr[gotWr.size()-1] == 0) ? rdVal : 16'hDEAD;
          pend = 0;
          txnIdx++;
        end else cnt--;
      end
      dsReady = !pend && (stallOn ? cycle[0] : 1'b1);
    end
  end

  task automatic run(input string tag, input bit wr, input logic [31:0] tgt,
                     input logic [15:0] wd, input int eAt, input logic [15:0] rv,
                     input int lat, input bit stall, input bit holdValid);
    int expReg[$];
    int expWr[$];
    int expData[$];
    int n;
    bit expErr;
    int expRd;
    int guard;
    logic [15:0] dev;
    dev = tgt[31:16];
    if (dev == 0) begin
      expReg.push_back(tgt[4:0]); expWr.push_back(wr); expData.push_back(wr ? wd : 0);
    end else begin
      expReg.push_back(13); expWr.push_back(1); expData.push_back(dev);
      expReg.push_back(14); expWr.push_back(1); expData.push_back(tgt[15:0]);
      expReg.push_back(13); expWr.push_back(1); expData.push_back(dev | 16'h4000);
      expReg.push_back(14); expWr.push_back(wr); expData.push_back(wr ? wd : 0);
      expReg.push_back(13); expWr.push_back(1); expData.push_back(0);
    end
    n = (eAt >= 0 && eAt < expReg.size()) ? eAt + 1 : expReg.size();
    expErr = (eAt >= 0 && eAt < expReg.size());
    expRd = (expErr || wr) ? 0 : rv;
    gotReg.delete(); gotWr.delete(); gotData.delete();
    txnIdx = 0; errAt = eAt; rdVal = rv; latency = lat; stallOn = stall;
    doneSeen = 0; acceptSeen = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqTarget = tgt; reqWdata = wd;
    guard = 0;
    while (!acceptSeen && guard < 100) begin @(negedge clk); guard++; end
    if (holdValid) begin reqTarget = 32'h0000_0003; reqWrite = 1'b1; end
    else reqValid = 1'b0;
    guard = 0;
    while (doneSeen == 0 && guard < 500) begin @(negedge clk); guard++; end
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    chk(doneSeen == 1, {tag, " R10 single done"}, doneSeen, 1);
    chk(doneCycle == lastCplCycle + 1, {tag, " R10 done timing"}, doneCycle, lastCplCycle + 1);
    chk(gotReg.size() == n, {tag, " access count (R7/R9)"}, gotReg.size(), n);
    for (int i = 0; i < n && i < gotReg.size(); i++) begin
      chk(gotReg[i] == expReg[i], {tag, $sformatf(" R3 R4 R5 R6 R2 step %0d reg", i)}, gotReg[i], expReg[i]);
      chk(gotWr[i] == expWr[i], {tag, $sformatf(" step %0d write flag", i)}, gotWr[i], expWr[i]);
      chk(gotData[i] == expData[i], {tag, $sformatf(" step %0d data", i)}, gotData[i], expData[i]);
    end
    chk(doneErrS == expErr, {tag, " R7 doneErr"}, doneErrS, expErr);
    chk(doneRdS == expRd, {tag, " R5 doneRdata"}, doneRdS, expRd);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    chk(dsValid == 1'b0, "R1 dsValid", dsValid, 0);
    chk(doneValid == 1'b0, "R1 doneValid", doneValid, 0);
    rst_n = 1'b1;
    resetDone = 1;
    @(negedge clk);
    run("R2 direct write",   1, 32'h0000_0009, 16'h1234, -1, 16'h0,    0, 0, 0);
    run("R2 direct read",    0, 32'h0000_0001, 16'h0,    -1, 16'h796D, 3, 0, 0);
    run("R2 direct mask",    0, 32'h0000_00FF, 16'h0,    -1, 16'h0F0F, 1, 1, 0);
    run("R5 indirect read",  0, 32'h0007_0020, 16'h0,    -1, 16'hBEEF, 0, 1, 0);
    run("R9 indirect write", 1, 32'h0003_1234, 16'hA5A5, -1, 16'h0,    2, 0, 1);
    run("R7 err step0",      1, 32'h0001_0005, 16'h5555,  0, 16'h0,    1, 0, 0);
    run("R7 err step2",      0, 32'h0002_0006, 16'h0,     2, 16'h1111, 0, 1, 0);
    run("R7 err step3",      0, 32'h0004_0008, 16'h0,     3, 16'h2222, 1, 0, 0);
    run("R7 err step4",      0, 32'h001F_0010, 16'h0,     4, 16'h3333, 0, 0, 0);
    run("R4 boundary",       0, 32'hFFFF_FFFF, 16'h0,    -1, 16'hFFFF, 2, 1, 0);
    run("R7 direct err",     0, 32'h0000_0002, 16'h0,     0, 16'h4444, 0, 0, 0);
    run("R6 write back2back",1, 32'h8000_0001, 16'h0001, -1, 16'h0,    0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule